// File: doc/BRIEF.md
# Bidirectional Split Instruction Fetcher

This block fetches wide instructions that are stored as two halves around a centre point in memory. A new entry address loads two program counters with the same value. One counter walks upward through memory and reads a one-word header, then the operation words of the upward half. The other counter walks downward and reads the operation words of the downward half. The header at the centre gives the number of operation slots in each half, so empty slots take up no memory. Each half fills its own slot register file through a separate, simple write path.

When both halves of an instruction have been collected, the block raises `instValid` for one cycle. During that cycle it presents the upward and downward slot vectors, each with a valid mask. A functional unit may start working on any slot word as soon as it appears, and it must discard the result when that slot's valid bit is low. Fetching then carries on with the next instruction. Its header sits just above the previous upward half, and its downward half sits just below the previous downward half. A new entry address stops the instruction in progress at once and restarts at the new centre. Memory is read through a single port with a combinational read.

Top module: `split_fetch`

## Requirements
- R1: After reset, and until the first entry address arrives, `memRd`, `instValid`, `upValid` and `dnValid` are all low.
- R2: In the cycle after `startValid` is sampled high, `memRd` is high and `memAddr` equals the entry address that was sampled, which is the header word of the first instruction.
- R3: The header's bits [3:0] give the upward slot count and bits [7:4] give the downward slot count. In the `instValid` cycle, bit i of `upValid` (or `dnValid`) is 1 exactly when i is below that half's count.
- R4: Upward slot k holds the word at centre + 1 + k.
- R5: Downward slot k holds the word at centre − 1 − k. The next instruction's downward half continues directly below the previous one.
- R6: The next instruction's header is read from centre + 1 + upward count. In the `instValid` cycle, `memAddr` shows that address.
- R7: Consecutive `instValid` pulses are exactly 1 + upward count + downward count cycles apart: one header read plus one read per slot.
- R8: A header with both counts zero produces an `instValid` pulse one cycle after its header read, with both valid masks all zero.
- R9: A `startValid` that arrives while an instruction is in progress abandons it: no `instValid` is raised for it. The next pulse carries the instruction found at the new address.
- R10: `upValid` and `dnValid` are all zero in every cycle in which `instValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Load a new centre address |
| startAddr | input | ADDR_W | Centre (header) address of the entry instruction |
| memRd | output | 1 | Read strobe for the memory port |
| memAddr | output | ADDR_W | Word address being read |
| memRdData | input | OP_W | Read data, combinational from memAddr |
| instValid | output | 1 | One-cycle strobe: slot vectors hold a complete instruction |
| upOps | output | SLOTS*OP_W | Upward-half slot words, slot 0 in the low bits |
| upValid | output | SLOTS | Upward-half slot valid mask |
| dnOps | output | SLOTS*OP_W | Downward-half slot words, slot 0 in the low bits |
| dnValid | output | SLOTS | Downward-half slot valid mask |

## Verification
The hardest case to reach from the ports is a restart that lands in the middle of an instruction. The intended effect is that nothing happens: no pulse and no partial masks. The bench restarts into a long instruction and, two cycles later, redirects the fetcher to a different centre, so the first instruction is still collecting its upward slots. It then checks that no pulse appears and that the next pulse carries the second centre's slots on time. A table-driven run of six chained instructions also covers the empty header, full 15+15 halves, and halves where one side is empty. In that run, the downward address keeps accumulating across instructions.

// File: rtl/split_fetch_pkg.sv
package split_fetch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_UP,
    ST_DN
  } fetchState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic active;   // a read is issued this cycle
    logic restart;  // load both counters from startAddr
    logic loadHdr;  // capture slot counts from the header word
    logic fetchUp;  // store upward slot, advance upward counter
    logic fetchDn;  // store downward slot, retreat downward counter
    logic selDn;    // address comes from the downward counter
    logic commit;   // instruction complete, publish valid masks
  } fetchStrobe_t;

endpackage

// File: rtl/split_fetch_ctrl.sv
module split_fetch_ctrl
  import split_fetch_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [CNT_W-1:0] hdrUp,
  input  logic [CNT_W-1:0] hdrDn,
  input  logic [CNT_W-1:0] upCnt,
  input  logic [CNT_W-1:0] dnCnt,
  output fetchStrobe_t     stb,
  output logic [CNT_W-1:0] slotIdx,
  output logic             instValid
);

  fetchState_t state, nextState;
  logic [CNT_W-1:0] nextIdx;

  always_comb begin
    stb       = '0;
    nextState = state;
    nextIdx   = slotIdx;
    stb.active = (state != ST_IDLE);
    stb.selDn  = (state == ST_DN);
    if (startValid) begin
      stb.restart = 1'b1;
      nextState   = ST_HDR;
      nextIdx     = '0;
    end else begin
      unique case (state)
        ST_HDR: begin
          stb.loadHdr = 1'b1;
          nextIdx     = '0;
          if (hdrUp != '0)      nextState = ST_UP;
          else if (hdrDn != '0) nextState = ST_DN;
          else                  stb.commit = 1'b1;
        end
        ST_UP: begin
          stb.fetchUp = 1'b1;
          if (slotIdx == upCnt - CNT_W'(1)) begin
            nextIdx = '0;
            if (dnCnt != '0) nextState = ST_DN;
            else begin
              stb.commit = 1'b1;
              nextState  = ST_HDR;
            end
          end else begin
            nextIdx = slotIdx + CNT_W'(1);
          end
        end
        ST_DN: begin
          stb.fetchDn = 1'b1;
          if (slotIdx == dnCnt - CNT_W'(1)) begin
            nextIdx    = '0;
            stb.commit = 1'b1;
            nextState  = ST_HDR;
          end else begin
            nextIdx = slotIdx + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      slotIdx   <= '0;
      instValid <= 1'b0;
    end else begin
      state     <= nextState;
      slotIdx   <= nextIdx;
      instValid <= stb.commit;
    end
  end

  // R4: the upward slot index stays inside the decoded upward count
  p_up_idx_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UP) |-> (slotIdx < upCnt));

  // R5: the downward slot index stays inside the decoded downward count
  p_dn_idx_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DN) |-> (slotIdx < dnCnt));

  // R9: a restart never publishes the abandoned instruction
  p_restart_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> !instValid);

endmodule

// File: rtl/split_fetch_dp.sv
module split_fetch_dp
  import split_fetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OP_W   = 32,
  parameter int CNT_W  = 4,
  parameter int SLOTS  = 15
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fetchStrobe_t          stb,
  input  logic [CNT_W-1:0]      slotIdx,
  input  logic [ADDR_W-1:0]     startAddr,
  input  logic [OP_W-1:0]       memRdData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memRd,
  output logic [CNT_W-1:0]      hdrUp,
  output logic [CNT_W-1:0]      hdrDn,
  output logic [CNT_W-1:0]      upCnt,
  output logic [CNT_W-1:0]      dnCnt,
  output logic [SLOTS*OP_W-1:0] upOps,
  output logic [SLOTS*OP_W-1:0] dnOps,
  output logic [SLOTS-1:0]      upValid,
  output logic [SLOTS-1:0]      dnValid
);

  logic [ADDR_W-1:0] upPc, dnPc;
  logic [CNT_W-1:0]  effUp, effDn;

  assign hdrUp   = memRdData[CNT_W-1:0];
  assign hdrDn   = memRdData[2*CNT_W-1:CNT_W];
  assign memAddr = stb.selDn ? (dnPc - ADDR_W'(1)) : upPc;
  assign memRd   = stb.active;

  // an empty header commits in the same cycle its counts arrive
  assign effUp = stb.loadHdr ? hdrUp : upCnt;
  assign effDn = stb.loadHdr ? hdrDn : dnCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upPc  <= '0;
      dnPc  <= '0;
      upCnt <= '0;
      dnCnt <= '0;
    end else if (stb.restart) begin
      upPc <= startAddr;
      dnPc <= startAddr;
    end else if (stb.loadHdr) begin
      upPc  <= upPc + ADDR_W'(1);
      upCnt <= hdrUp;
      dnCnt <= hdrDn;
    end else if (stb.fetchUp) begin
      upPc <= upPc + ADDR_W'(1);
    end else if (stb.fetchDn) begin
      dnPc <= dnPc - ADDR_W'(1);
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [OP_W-1:0] upWord, dnWord;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        upWord     <= '0;
        dnWord     <= '0;
        upValid[i] <= 1'b0;
        dnValid[i] <= 1'b0;
      end else begin
        if (stb.fetchUp && slotIdx == CNT_W'(i)) upWord <= memRdData;
        if (stb.fetchDn && slotIdx == CNT_W'(i)) dnWord <= memRdData;
        upValid[i] <= stb.commit && (CNT_W'(i) < effUp);
        dnValid[i] <= stb.commit && (CNT_W'(i) < effDn);
      end
    end
    assign upOps[i*OP_W +: OP_W] = upWord;
    assign dnOps[i*OP_W +: OP_W] = dnWord;
  end

  // R6: the downward counter never passes above the upward counter
  p_pc_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.active |-> (dnPc <= upPc));

  // R3: published masks are contiguous from slot 0
  p_contig_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((upValid & (upValid + SLOTS'(1))) == '0) && ((dnValid & (dnValid + SLOTS'(1))) == '0));

  // R3: the number of valid upward slots equals the decoded count
  p_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> ($countones(upValid) == $past(int'(effUp))));

endmodule

// File: rtl/split_fetch.sv
module split_fetch
  import split_fetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OP_W   = 32,
  parameter int CNT_W  = 4,
  localparam int SLOTS = (1 << CNT_W) - 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startValid,
  input  logic [ADDR_W-1:0]     startAddr,
  output logic                  memRd,
  output logic [ADDR_W-1:0]     memAddr,
  input  logic [OP_W-1:0]       memRdData,
  output logic                  instValid,
  output logic [SLOTS*OP_W-1:0] upOps,
  output logic [SLOTS-1:0]      upValid,
  output logic [SLOTS*OP_W-1:0] dnOps,
  output logic [SLOTS-1:0]      dnValid
);

  fetchStrobe_t     stb;
  logic [CNT_W-1:0] slotIdx, hdrUp, hdrDn, upCnt, dnCnt;

  split_fetch_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .hdrUp(hdrUp), .hdrDn(hdrDn), .upCnt(upCnt), .dnCnt(dnCnt),
    .stb(stb), .slotIdx(slotIdx), .instValid(instValid)
  );

  split_fetch_dp #(.ADDR_W(ADDR_W), .OP_W(OP_W), .CNT_W(CNT_W), .SLOTS(SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .slotIdx(slotIdx),
    .startAddr(startAddr), .memRdData(memRdData),
    .memAddr(memAddr), .memRd(memRd),
    .hdrUp(hdrUp), .hdrDn(hdrDn), .upCnt(upCnt), .dnCnt(dnCnt),
    .upOps(upOps), .dnOps(dnOps), .upValid(upValid), .dnValid(dnValid)
  );

  // R2: the header read follows the entry address directly
  p_start_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> (memRd && memAddr == $past(startAddr)));

  // R10: slot valid bits only appear with the instruction strobe
  p_valid_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> (upValid == '0 && dnValid == '0));

endmodule

// File: tb/split_fetch_bench.sv
`timescale 1ns/1ps
module split_fetch_bench;
  localparam int ADDR_W = 16;
  localparam int OP_W   = 32;
  localparam int CNT_W  = 4;
  localparam int SLOTS  = 15;
  localparam int VEC_N  = 6;
  // header bytes {down count, up count}
  localparam logic [7:0] VEC [VEC_N] = '{8'h23, 8'h40, 8'h05, 8'h00, 8'hFF, 8'h11};
  localparam int BASE = 128;
  localparam int ALT  = 200;

  logic clk = 1'b0, rstN = 1'b0, startValid = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic memRd, instValid;
  logic [ADDR_W-1:0] memAddr;
  logic [OP_W-1:0] memRdData;
  logic [SLOTS*OP_W-1:0] upOps, dnOps;
  logic [SLOTS-1:0] upValid, dnValid;
  logic [OP_W-1:0] mem [256];

  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  assign memRdData = mem[memAddr[7:0]];

  split_fetch u_split_fetch (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .memRd(memRd), .memAddr(memAddr), .memRdData(memRdData),
    .instValid(instValid), .upOps(upOps), .upValid(upValid),
    .dnOps(dnOps), .dnValid(dnValid)
  );

  function automatic logic [OP_W-1:0] opWord(int a);
    return 32'hA500_0000 | OP_W'(a);
  endfunction

  function automatic logic [SLOTS-1:0] maskOf(int n);
    return SLOTS'((1 << n) - 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // waits for the next strobe, counting cycles and stray valid bits
  task automatic waitInst(output int gap, output bit stray);
    gap = 0;
    stray = 1'b0;
    do begin
      @(negedge clk);
      gap++;
      if (!instValid && (upValid != '0 || dnValid != '0)) stray = 1'b1;
    end while (!instValid && gap < 200);
    if (gap >= 200) chk(1'b0, "watchdog", 64'(gap), 64'd0);
  endtask

  initial begin
    int gap;
    bit stray;
    int up, dn, bad;

    for (int a = 0; a < 256; a++) mem[a] = opWord(a);
    up = BASE;
    for (int v = 0; v < VEC_N; v++) begin
      mem[up] = {24'h0, VEC[v]};
      up = up + 1 + int'(VEC[v][3:0]);
    end
    mem[ALT] = {24'h0, 8'h12};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(memRd == 1'b0, "R1 memRd after reset", 64'(memRd), 64'd0);
    chk(instValid == 1'b0, "R1 instValid after reset", 64'(instValid), 64'd0);
    chk(upValid == '0 && dnValid == '0, "R1 masks after reset", 64'({upValid, dnValid}), 64'd0);

    startValid = 1'b1;
    startAddr  = ADDR_W'(BASE);
    @(negedge clk);
    startValid = 1'b0;
    chk(memRd && memAddr == ADDR_W'(BASE), "R2 header address", 64'({memRd, memAddr}), 64'({1'b1, 16'(BASE)}));

    up = BASE;
    dn = BASE;
    for (int v = 0; v < VEC_N; v++) begin
      int nU, nD;
      nU = int'(VEC[v][3:0]);
      nD = int'(VEC[v][7:4]);
      waitInst(gap, stray);
      chk(gap == 1 + nU + nD, "R7 strobe spacing", 64'(gap), 64'(1 + nU + nD));
      chk(!stray, "R10 masks outside strobe", 64'(stray), 64'd0);
      chk(upValid == maskOf(nU) && dnValid == maskOf(nD), "R3 slot masks",
          64'({upValid, dnValid}), 64'({maskOf(nU), maskOf(nD)}));
      bad = 0;
      for (int k = 0; k < nU; k++) if (upOps[k*OP_W +: OP_W] != opWord(up + 1 + k)) bad++;
      chk(bad == 0, "R4 upward slot words", 64'(bad), 64'd0);
      bad = 0;
      for (int k = 0; k < nD; k++) if (dnOps[k*OP_W +: OP_W] != opWord(dn - 1 - k)) bad++;
      chk(bad == 0, "R5 downward slot words", 64'(bad), 64'd0);
      chk(memAddr == ADDR_W'(up + 1 + nU), "R6 next header address", 64'(memAddr), 64'(up + 1 + nU));
      if (nU + nD == 0)
        chk(gap == 1 && upValid == '0 && dnValid == '0, "R8 empty header",
            64'({gap[7:0], upValid, dnValid}), 64'({8'd1, 30'd0}));
      up = up + 1 + nU;
      dn = dn - nD;
    end

    // restart into a long instruction, then redirect mid-way
    startValid = 1'b1;
    startAddr  = ADDR_W'(BASE);
    @(negedge clk);
    startValid = 1'b0;
    stray = 1'b0;
    repeat (2) begin
      @(negedge clk);
      if (instValid) stray = 1'b1;
    end
    startValid = 1'b1;
    startAddr  = ADDR_W'(ALT);
    @(negedge clk);
    startValid = 1'b0;
    if (instValid) stray = 1'b1;
    chk(!stray, "R9 no strobe for abandoned instruction", 64'(stray), 64'd0);
    waitInst(gap, stray);
    chk(gap == 4 && upValid == maskOf(2) && dnValid == maskOf(1), "R9 redirected timing and masks",
        64'({gap[7:0], upValid, dnValid}), 64'({8'd4, maskOf(2), maskOf(1)}));
    chk(upOps[0 +: OP_W] == opWord(ALT + 1) && upOps[OP_W +: OP_W] == opWord(ALT + 2)
        && dnOps[0 +: OP_W] == opWord(ALT - 1), "R9 redirected slot words",
        64'(upOps[0 +: OP_W]), 64'(opWord(ALT + 1)));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule